// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words that sits between two unrelated clock domains. The writer pushes words on its own clock, the reader pops them on a second clock, and a depth parameter sizes the storage at 512, 1024, 2048 or 4096 words. Four active-low status outputs are provided: empty and almost-empty belong to the read domain, while full and almost-full belong to the write domain. Each almost flag compares the fill level against a 9-bit offset register. Both offsets start at 7.

The second write-enable input has two uses, and its level during reset chooses between them. If it is held high through reset, the block is in dual-enable mode: a write needs both write enables low. If it is held low through reset, the block is in load mode: the pin becomes a load strobe, and the first write enable alone controls data writes. In load mode, strobe plus write enable stores the offsets in turn, almost-empty first and then almost-full. Strobe plus both read enables returns them in the same order through the data output register. The output register is cleared by reset. An output enable masks the data to zero and lowers a valid signal; this stands in for a high-impedance output.

Top module: `dcfifo_pflag`

## Requirements
- R1: While rst_n is low and after its release, empty_n and aempty_n are 0, full_n and afull_n are 1, and rd_data is all zeros. Both offsets return to 7 and both pointers return to location zero.
- R2: A data read occurs only on a rising rd_clk edge at which rd_en1_n and rd_en2_n are both 0 and empty_n is 1. Reads requested while empty, or with only one read enable low, leave rd_data and the fill level unchanged.
- R3: full_n is 0 exactly when DEPTH words are stored. A write attempted while full_n is 0 stores nothing and overwrites nothing. full_n returns to 1 after a read, within a few write clocks.
- R4: Words leave in the order they were written. A popped word appears on rd_data after the rd_clk edge that performs the read.
- R5: aempty_n is 0 while the fill level is less than or equal to the almost-empty offset (7 after reset), and 1 above it.
- R6: afull_n is 0 while the fill level is greater than or equal to DEPTH minus the almost-full offset (7 after reset), and 1 below it.
- R7: If wr_en2_ld_n is 1 during reset, dual-enable mode is selected: a word is written only when wr_en1_n and wr_en2_ld_n are both 0, and wr_en1_n alone writes nothing.
- R8: If wr_en2_ld_n is 0 during reset, load mode is selected. wr_en1_n=0 with wr_en2_ld_n=1 writes data. wr_en1_n=0 with wr_en2_ld_n=0 stores wr_data into the almost-empty offset and then the almost-full offset, alternating. Both read enables low with wr_en2_ld_n=0 loads those offsets, in the same order, into rd_data. None of these offset operations changes the fill level.
- R9: When oe_n is 1, rd_data is all zeros and rd_data_vld is 0. When oe_n is 0, rd_data shows the output register and rd_data_vld is 1.
- R10: Pointers cross between domains in Gray code through SYNC_STAGES flip-flops. empty_n stays 0 for at least the first read edge after a write into an empty buffer. It rises within SYNC_STAGES+2 read edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2_ld_n | input | 1 | Second write enable or offset load strobe, active low, level sampled at reset |
| wr_data | input | DATA_W | Write data or offset value |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | output | DATA_W | Registered read data, zero when masked |
| rd_data_vld | output | 1 | High while rd_data is driven |
| empty_n | output | 1 | Empty flag, active low, read domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read domain |
| full_n | output | 1 | Full flag, active low, write domain |
| afull_n | output | 1 | Almost-full flag, active low, write domain |

## Verification
Flags owned by a clock domain, together with the output register, update on the same edge as the write or read that changes them. The bench therefore samples them half a period after that edge. Flag changes caused by the other domain arrive through the synchronizer and then the flag register, which takes SYNC_STAGES+1 edges of the observing clock. The bench waits eight edges of each clock before checking any cross-domain result. One check samples empty_n a single read edge after a write, to confirm that a flag never clears too early.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

   typedef enum logic {
      WMODE_DUAL_EN = 1'b0,
      WMODE_LOAD    = 1'b1
   } wmode_e;

   typedef enum logic {
      OSEL_LOW_SIDE  = 1'b0,
      OSEL_HIGH_SIDE = 1'b1
   } osel_e;

   localparam int unsigned DEF_OFFSET = 7;

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
   parameter int W      = 10,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] gray_in,
   output logic [W-1:0] bin_out
);
   logic [W-1:0] stg [STAGES];
   logic [W-1:0] g_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= gray_in;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign g_last = stg[STAGES-1];

   for (genvar b = 0; b < W; b++) begin : g_g2b
      assign bin_out[b] = ^(g_last >> b);
   end

endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
   parameter int DATA_W = 9,
   parameter int AW     = 9
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int WORDS = 1 << AW;

   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
   import dcf_pkg::*;
#(
   parameter int DATA_W = 9,
   parameter int AW     = 9,
   parameter int DEPTH  = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wen1_n,
   input  logic              wen2_ld_n,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW:0]       rbin_s,
   output logic              ram_we,
   output logic [AW-1:0]     waddr,
   output logic [AW:0]       wgray,
   output logic              full_n,
   output logic              afull_n,
   output logic [DATA_W-1:0] ae_off,
   output logic [DATA_W-1:0] af_off
);
   localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

   wmode_e            mode_q;
   osel_e             osel_q;
   logic [AW:0]       wbin_q, wbin_nxt, level_nxt, thr;
   logic [DATA_W-1:0] ae_q, af_q;
   logic              wr_req, push, off_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= wen2_ld_n ? WMODE_DUAL_EN : WMODE_LOAD;
      else        mode_q <= mode_q;
   end

   always_comb begin
      off_wr    = (mode_q == WMODE_LOAD) && !wen1_n && !wen2_ld_n;
      wr_req    = !wen1_n && ((mode_q == WMODE_LOAD) ? wen2_ld_n : !wen2_ld_n);
      push      = wr_req && full_n;
      wbin_nxt  = wbin_q + (AW+1)'(push);
      level_nxt = wbin_nxt - rbin_s;
      thr       = DEPTH_V - (AW+1)'(af_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin_q  <= '0;
         wgray   <= '0;
         full_n  <= 1'b1;
         afull_n <= 1'b1;
      end else begin
         wbin_q  <= wbin_nxt;
         wgray   <= wbin_nxt ^ (wbin_nxt >> 1);
         full_n  <= (level_nxt != DEPTH_V);
         afull_n <= (level_nxt < thr);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osel_q <= OSEL_LOW_SIDE;
         ae_q   <= DATA_W'(DEF_OFFSET);
         af_q   <= DATA_W'(DEF_OFFSET);
      end else if (off_wr) begin
         if (osel_q == OSEL_LOW_SIDE) begin
            ae_q   <= wdata;
            osel_q <= OSEL_HIGH_SIDE;
         end else begin
            af_q   <= wdata;
            osel_q <= OSEL_LOW_SIDE;
         end
      end
   end

   assign ram_we = push;
   assign waddr  = wbin_q[AW-1:0];
   assign ae_off = ae_q;
   assign af_off = af_q;

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n |=> (wbin_q == $past(wbin_q)));

   assert_full_in_afull_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n |-> !afull_n);

   assert_mode_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(mode_q));

   assert_wgray_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));

endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
   import dcf_pkg::*;
#(
   parameter int DATA_W = 9,
   parameter int AW     = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ren1_n,
   input  logic              ren2_n,
   input  logic              ld_n,
   input  logic [DATA_W-1:0] ae_off,
   input  logic [DATA_W-1:0] af_off,
   input  logic [AW:0]       wbin_s,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic [AW-1:0]     raddr,
   output logic [AW:0]       rgray,
   output logic              empty_n,
   output logic              aempty_n,
   output logic [DATA_W-1:0] q
);
   wmode_e      mode_q;
   osel_e       osel_q;
   logic [AW:0] rbin_q, rbin_nxt, level_nxt;
   logic        rd_req, ld_act, pop, off_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= ld_n ? WMODE_DUAL_EN : WMODE_LOAD;
      else        mode_q <= mode_q;
   end

   always_comb begin
      rd_req    = !ren1_n && !ren2_n;
      ld_act    = (mode_q == WMODE_LOAD) && !ld_n;
      off_rd    = rd_req && ld_act;
      pop       = rd_req && !ld_act && empty_n;
      rbin_nxt  = rbin_q + (AW+1)'(pop);
      level_nxt = wbin_s - rbin_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin_q   <= '0;
         rgray    <= '0;
         empty_n  <= 1'b0;
         aempty_n <= 1'b0;
      end else begin
         rbin_q   <= rbin_nxt;
         rgray    <= rbin_nxt ^ (rbin_nxt >> 1);
         empty_n  <= (level_nxt != '0);
         aempty_n <= (level_nxt > (AW+1)'(ae_off));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q      <= '0;
         osel_q <= OSEL_LOW_SIDE;
      end else if (pop) begin
         q <= ram_rdata;
      end else if (off_rd) begin
         if (osel_q == OSEL_LOW_SIDE) begin
            q      <= ae_off;
            osel_q <= OSEL_HIGH_SIDE;
         end else begin
            q      <= af_off;
            osel_q <= OSEL_LOW_SIDE;
         end
      end
   end

   assign raddr = rbin_q[AW-1:0];

   assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !empty_n |=> (rbin_q == $past(rbin_q)));

   assert_empty_in_aempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !empty_n |-> !aempty_n);

   assert_rgray_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(rgray ^ $past(rgray)) <= 1));

endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
   parameter int DATA_W      = 9,
   parameter int DEPTH       = 512,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              wr_en1_n,
   input  logic              wr_en2_ld_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en1_n,
   input  logic              rd_en2_n,
   input  logic              oe_n,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_data_vld,
   output logic              empty_n,
   output logic              aempty_n,
   output logic              full_n,
   output logic              afull_n
);
   localparam int AW = $clog2(DEPTH);

   if (!(DEPTH == 512 || DEPTH == 1024 || DEPTH == 2048 || DEPTH == 4096)) begin : g_bad_depth
      $error("dcfifo_pflag: DEPTH must be 512, 1024, 2048 or 4096");
   end
   if (DATA_W < 1 || DATA_W > AW + 1) begin : g_bad_width
      $error("dcfifo_pflag: DATA_W must lie in 1..AW+1");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("dcfifo_pflag: SYNC_STAGES must be 2 or 3");
   end

   logic              ram_we;
   logic [AW-1:0]     waddr, raddr;
   logic [AW:0]       wgray, rgray, wbin_s, rbin_s;
   logic [DATA_W-1:0] ae_off, af_off, ram_rdata, q;

   dcf_wr_ctl #(.DATA_W(DATA_W), .AW(AW), .DEPTH(DEPTH)) u_wr (
      .clk      (wr_clk),
      .rst_n    (rst_n),
      .wen1_n   (wr_en1_n),
      .wen2_ld_n(wr_en2_ld_n),
      .wdata    (wr_data),
      .rbin_s   (rbin_s),
      .ram_we   (ram_we),
      .waddr    (waddr),
      .wgray    (wgray),
      .full_n   (full_n),
      .afull_n  (afull_n),
      .ae_off   (ae_off),
      .af_off   (af_off)
   );

   dcf_rd_ctl #(.DATA_W(DATA_W), .AW(AW)) u_rd (
      .clk      (rd_clk),
      .rst_n    (rst_n),
      .ren1_n   (rd_en1_n),
      .ren2_n   (rd_en2_n),
      .ld_n     (wr_en2_ld_n),
      .ae_off   (ae_off),
      .af_off   (af_off),
      .wbin_s   (wbin_s),
      .ram_rdata(ram_rdata),
      .raddr    (raddr),
      .rgray    (rgray),
      .empty_n  (empty_n),
      .aempty_n (aempty_n),
      .q        (q)
   );

   dcf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
      .clk    (rd_clk),
      .rst_n  (rst_n),
      .gray_in(wgray),
      .bin_out(wbin_s)
   );

   dcf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
      .clk    (wr_clk),
      .rst_n  (rst_n),
      .gray_in(rgray),
      .bin_out(rbin_s)
   );

   dcf_ram #(.DATA_W(DATA_W), .AW(AW)) u_ram (
      .wclk (wr_clk),
      .we   (ram_we),
      .waddr(waddr),
      .wdata(wr_data),
      .raddr(raddr),
      .rdata(ram_rdata)
   );

   assign rd_data     = oe_n ? '0 : q;
   assign rd_data_vld = !oe_n;

endmodule

// File: tb/sim_dcfifo_pflag.sv
`timescale 1ns/100ps
module sim_dcfifo_pflag;
   localparam int DW = 9;
   localparam int DEPTH = 512;
   localparam int NV = 7;
   // vector: {fill level[11:0], empty_n, aempty_n, afull_n, full_n}
   localparam logic [15:0] VEC [NV] = '{
      {12'd1,   4'b1011}, {12'd7,   4'b1011}, {12'd8,   4'b1111},
      {12'd504, 4'b1111}, {12'd505, 4'b1101}, {12'd511, 4'b1101},
      {12'd512, 4'b1100}};

   logic wr_clk = 0, rd_clk = 0, rst_n = 0;
   logic wr_en1_n = 1, wr_en2_ld_n = 1, rd_en1_n = 1, rd_en2_n = 1, oe_n = 0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic rd_data_vld, empty_n, aempty_n, full_n, afull_n;

   int n_tests = 0, n_fail = 0, wr_cnt = 0, rd_cnt = 0;
   logic wr_dl = 1'b0;
   logic [DW-1:0] last;
   bit done = 0;

   always #2.5 wr_clk = ~wr_clk;
   always #3.7 rd_clk = ~rd_clk;

   dcfifo_pflag #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(2)) u0 (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
      .wr_en1_n(wr_en1_n), .wr_en2_ld_n(wr_en2_ld_n), .wr_data(wr_data),
      .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .oe_n(oe_n),
      .rd_data(rd_data), .rd_data_vld(rd_data_vld), .empty_n(empty_n),
      .aempty_n(aempty_n), .full_n(full_n), .afull_n(afull_n));

   function automatic logic [DW-1:0] pat(int i);
      return DW'((i * 37 + 5) & 511);
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(logic mode_pin);
      rst_n = 0; wr_en1_n = 1; rd_en1_n = 1; rd_en2_n = 1; wr_en2_ld_n = mode_pin;
      repeat (4) @(posedge rd_clk);
      @(negedge wr_clk); rst_n = 1;
      @(negedge wr_clk); wr_en2_ld_n = 1;
      wr_dl = mode_pin ? 1'b0 : 1'b1;
      wr_cnt = 0; rd_cnt = 0;
   endtask

   task automatic wr_one();
      @(negedge wr_clk);
      wr_data = pat(wr_cnt); wr_en1_n = 0; wr_en2_ld_n = wr_dl;
      @(negedge wr_clk);
      wr_en1_n = 1; wr_en2_ld_n = 1;
      wr_cnt++;
   endtask

   task automatic rd_one();
      @(negedge rd_clk); rd_en1_n = 0; rd_en2_n = 0;
      @(negedge rd_clk); rd_en1_n = 1; rd_en2_n = 1;
   endtask

   task automatic settle();
      repeat (8) @(negedge rd_clk);
      repeat (8) @(negedge wr_clk);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // dual-enable mode
      do_reset(1'b1);
      @(negedge rd_clk);
      chk("R1 empty_n", empty_n, 0); chk("R1 aempty_n", aempty_n, 0);
      chk("R1 full_n", full_n, 1);   chk("R1 afull_n", afull_n, 1);
      chk("R1 rd_data", rd_data, 0); chk("R9 vld", rd_data_vld, 1);

      // R7: one enable alone writes nothing
      @(negedge wr_clk); wr_data = 9'h55; wr_en1_n = 0; wr_en2_ld_n = 1;
      @(negedge wr_clk); wr_en1_n = 1;
      settle();
      chk("R7 single enable", empty_n, 0);

      // R10: empty flag must not clear one read edge after a write
      @(negedge wr_clk); wr_data = pat(0); wr_en1_n = 0; wr_en2_ld_n = 0;
      @(posedge wr_clk); #0.5; wr_en1_n = 1; wr_en2_ld_n = 1; wr_cnt = 1;
      @(posedge rd_clk); #0.5;
      chk("R10 early empty", empty_n, 0);
      settle();
      chk("R10 empty clears", empty_n, 1);

      // table walk of flag points at default offsets (R5 R6 R3)
      for (int v = 0; v < NV; v++) begin
         while (wr_cnt < int'(VEC[v][15:4])) wr_one();
         settle();
         chk("R5 empty_n", empty_n, VEC[v][3]);
         chk("R5 aempty_n", aempty_n, VEC[v][2]);
         chk("R6 afull_n", afull_n, VEC[v][1]);
         chk("R3 full_n", full_n, VEC[v][0]);
      end

      // R3: write while full is blocked
      @(negedge wr_clk); wr_data = 9'h0AA; wr_en1_n = 0; wr_en2_ld_n = 0;
      @(negedge wr_clk); wr_en1_n = 1; wr_en2_ld_n = 1;
      settle();
      chk("R3 still full", full_n, 0);

      // R4: drain in order
      for (int i = 0; i < DEPTH; i++) begin
         rd_one();
         chk("R4 order", rd_data, pat(rd_cnt));
         rd_cnt++;
         if (i == 0) begin
            settle();
            chk("R3 full clears", full_n, 1);
         end
      end
      settle();
      chk("R2 empty", empty_n, 0); chk("R5 aempty", aempty_n, 0);

      // R2: read while empty ignored
      last = rd_data;
      rd_one();
      chk("R2 read on empty", rd_data, last);

      // R2: one read enable alone does nothing
      wr_one(); settle();
      @(negedge rd_clk); rd_en1_n = 0; rd_en2_n = 1;
      @(negedge rd_clk); rd_en1_n = 1;
      settle();
      chk("R2 single rd enable", rd_data, last);
      chk("R2 level kept", empty_n, 1);
      rd_one();
      chk("R4 next word", rd_data, pat(rd_cnt)); rd_cnt++;

      // R9: output enable
      last = rd_data;
      oe_n = 1; #1;
      chk("R9 masked data", rd_data, 0); chk("R9 masked vld", rd_data_vld, 0);
      oe_n = 0; #1;
      chk("R9 driven data", rd_data, last); chk("R9 driven vld", rd_data_vld, 1);

      // load mode
      do_reset(1'b0);
      @(negedge rd_clk);
      chk("R1 load rd_data", rd_data, 0); chk("R1 load aempty_n", aempty_n, 0);
      @(negedge wr_clk); wr_data = 9'd20; wr_en1_n = 0; wr_en2_ld_n = 0;
      @(negedge wr_clk); wr_data = 9'd30;
      @(negedge wr_clk); wr_en1_n = 1; wr_en2_ld_n = 1;
      @(negedge rd_clk); wr_en2_ld_n = 0; rd_en1_n = 0; rd_en2_n = 0;
      @(negedge rd_clk); chk("R8 readback ae", rd_data, 20);
      @(negedge rd_clk); chk("R8 readback af", rd_data, 30);
      rd_en1_n = 1; rd_en2_n = 1; wr_en2_ld_n = 1;
      settle();
      chk("R8 offsets not data", empty_n, 0);

      while (wr_cnt < 20) wr_one();
      settle(); chk("R5 loaded at 20", aempty_n, 0);
      wr_one(); settle(); chk("R5 loaded at 21", aempty_n, 1);
      while (wr_cnt < 481) wr_one();
      settle(); chk("R6 loaded at 481", afull_n, 1);
      wr_one(); settle(); chk("R6 loaded at 482", afull_n, 0);
      chk("R8 not full", full_n, 1);
      rd_one();
      chk("R8 data path", rd_data, pat(0));

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule